// File: doc/BRIEF.md
# 2D Drawing Engine Control and Status Registers

This block is the small register file in front of a 2D drawing accelerator. A simple bus with a valid strobe, a write flag, a word address and 32 bits of write data reaches four registers at four word offsets. Through them, software can pulse a reset into the engine, enable a completion interrupt, acknowledge that interrupt, and poll whether the engine is still rendering.

The engine reports the end of every command with a one-cycle done pulse, and the command launcher signals each new command with a one-cycle start strobe. The block keeps a sticky pending flag, which is armed only while the interrupt is enabled, and a live status bit. It drives the interrupt as a level that is the AND of the flag and the enable bit. It also raises a one-cycle hook when a software acknowledge actually clears a set flag. Software is expected to acknowledge any stale completion before it launches the next command.

Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `g2d_ctrl_regs`

## Requirements
- R1: After a hardware reset, reads return 0 at offset 0x4, 0 at offset 0xC and 1 at offset 0x10, and `irq` is low.
- R2: A write to offset 0x0 with data bit 0 set makes `eng_rst` high for exactly one cycle, the cycle after the write. A write to offset 0x0 with data bit 0 clear leaves `eng_rst` low.
- R3: In the cycle after `eng_rst` was high, the enable bit and the pending flag are 0, status bit 0 is 1, and `irq` is low.
- R4: Bit 0 at offset 0x4 is the interrupt enable, and it reads back the value last written. Bit 1 ignores writes and always reads 0.
- R5: An `eng_done` pulse while the enable bit is 1 sets pending bit 0 (offset 0xC) from the next cycle on. An `eng_done` pulse while the enable bit is 0 leaves it clear.
- R6: A write of 1 to pending bit 0 clears it in the next cycle. A write of 0 leaves it unchanged.
- R7: When an enabled `eng_done` pulse and a write of 1 to pending bit 0 arrive in the same cycle, the flag ends up set.
- R8: Status bit 0 (offset 0x10) goes to 0 in the cycle after a `cmd_start` pulse and goes to 1 in the cycle after an `eng_done` pulse. If both pulses arrive in the same cycle, it goes to 0.
- R9: `irq` is high exactly when the pending flag and the enable bit are both 1.
- R10: Offset 0x0, unmapped offsets such as 0x8, and bits [31:1] of every register read 0. Writes to offset 0x10 have no effect.
- R11: `pend_clr` is high for one cycle after a write of 1 to pending bit 0 that clears a set flag. It stays low when the flag was already clear and when a simultaneous `eng_done` keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| eng_done | input | 1 | One-cycle command-completion pulse from the engine |
| cmd_start | input | 1 | One-cycle strobe marking a new command launch |
| eng_rst | output | 1 | One-cycle software reset pulse to the engine |
| irq | output | 1 | Active-high level completion interrupt |
| pend_clr | output | 1 | One-cycle hook marking an acknowledged completion |

## Verification
The hardest case to reach is the collision in which an enabled completion lands in the same cycle as a software acknowledge. The stimulus drives `eng_done` together with the clearing write in a single cycle and then reads the flag back. It also checks that the clear hook stays quiet. A second collision drives `cmd_start` and `eng_done` together to pin the status ordering. The software reset is exercised only after every register has been moved away from its reset value, so that the restore is visible on the bus.

// File: rtl/g2d_ctrl_regs.sv
module g2d_ctrl_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_done,
  input  logic              cmd_start,
  output logic              eng_rst,
  output logic              irq,
  output logic              pend_clr
);

  localparam logic [ADDR_W-1:0] OFS_RST  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_PEND = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(5'h10);

  logic wr, rd, sel_rst, sel_en, sel_pend, sel_stat;
  logic rst_q, en_q, pend_q, stat_q, clr_q;
  logic fin_evt, ack_one;

  assign wr       = bus_valid & bus_write;
  assign rd       = bus_valid & ~bus_write;
  assign sel_rst  = bus_addr == OFS_RST;
  assign sel_en   = bus_addr == OFS_EN;
  assign sel_pend = bus_addr == OFS_PEND;
  assign sel_stat = bus_addr == OFS_STAT;
  assign fin_evt  = eng_done & en_q;
  assign ack_one  = wr & sel_pend & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      stat_q <= 1'b1;
      clr_q  <= 1'b0;
    end else begin
      rst_q <= wr & sel_rst & bus_wdata[0] & ~rst_q;
      if (rst_q) begin
        en_q   <= 1'b0;
        pend_q <= 1'b0;
        stat_q <= 1'b1;
        clr_q  <= 1'b0;
      end else begin
        if (wr && sel_en) en_q <= bus_wdata[0];
        if (fin_evt) pend_q <= 1'b1;
        else if (ack_one) pend_q <= 1'b0;
        clr_q <= ack_one & pend_q & ~fin_evt;
        if (cmd_start) stat_q <= 1'b0;
        else if (eng_done) stat_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (sel_en)   bus_rdata[0] = en_q;
      if (sel_pend) bus_rdata[0] = pend_q;
      if (sel_stat) bus_rdata[0] = stat_q;
    end
  end

  assign eng_rst  = rst_q;
  assign irq      = pend_q & en_q;
  assign pend_clr = clr_q;

  // R2
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !eng_rst);

  // R2
  rst_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_rst && bus_wdata[0] && !eng_rst) |=> eng_rst);

  // R3
  rst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> (!en_q && !pend_q && stat_q && !irq));

  // R5
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && en_q && !eng_rst) |=> pend_q);

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !eng_rst && !ack_one) |=> pend_q);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !eng_rst) |=> !stat_q);

  // R11
  clr_hook_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr |-> ($past(pend_q) && !pend_q));

endmodule

// File: tb/test_g2d_ctrl_regs.sv
`timescale 1ns/1ps
module test_g2d_ctrl_regs;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int SEL_RDATA = 0, SEL_IRQ = 1, SEL_RST = 2, SEL_CLR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, eng_done = 1'b0, cmd_start = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic eng_rst, irq, pend_clr;

  always #2.5 clk = ~clk;

  g2d_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW)) i_g2d_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_done(eng_done), .cmd_start(cmd_start), .eng_rst(eng_rst),
    .irq(irq), .pend_clr(pend_clr));

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  event  mon_ev;
  int    n_chk = 0, n_fail = 0;
  bit    finished = 0;

  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic dn, input logic st);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    eng_done = dn; cmd_start = st;
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0);
  endtask

  task automatic expect_v(input int sel, input logic [31:0] e, input string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    sb.push_back(it);
    -> mon_ev;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
    step(1, 0, a, '0, 0, 0);
    expect_v(SEL_RDATA, e, tag);
  endtask

  initial begin : monitor
    forever begin
      @(mon_ev);
      #0.5;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.sel)
          SEL_RDATA: act = bus_rdata;
          SEL_IRQ:   act = {31'd0, irq};
          SEL_RST:   act = {31'd0, eng_rst};
          default:   act = {31'd0, pend_clr};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #50000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h04, 0, "R1 enable");
    rd(5'h0C, 0, "R1 pending");
    rd(5'h10, 1, "R1 status");
    expect_v(SEL_IRQ, 0, "R1 irq");
    // R4 enable bit 0 stored, bit 1 dropped
    step(1, 1, 5'h04, 32'h3, 0, 0);
    rd(5'h04, 1, "R4 enable readback");
    // R10 write-only and unmapped offsets
    rd(5'h00, 0, "R10 reset reg read");
    rd(5'h08, 0, "R10 unmapped read");
    // R8 start clears status
    step(0, 0, '0, '0, 0, 1);
    rd(5'h10, 0, "R8 status after start");
    // R10 status write ignored
    step(1, 1, 5'h10, 32'h1, 0, 0);
    rd(5'h10, 0, "R10 status write ignored");
    // R8 / R5 / R9 done pulse
    step(0, 0, '0, '0, 1, 0);
    rd(5'h10, 1, "R8 status after done");
    rd(5'h0C, 1, "R5 pending set");
    expect_v(SEL_IRQ, 1, "R9 irq high");
    // R6 write 0 leaves flag
    step(1, 1, 5'h0C, 32'h0, 0, 0);
    rd(5'h0C, 1, "R6 write zero keeps");
    // R6 / R11 write 1 clears
    step(1, 1, 5'h0C, 32'h1, 0, 0);
    rd(5'h0C, 0, "R6 write one clears");
    expect_v(SEL_CLR, 1, "R11 hook pulse");
    expect_v(SEL_IRQ, 0, "R9 irq low");
    idle();
    expect_v(SEL_CLR, 0, "R11 hook one cycle");
    // R11 acking an already clear flag
    step(1, 1, 5'h0C, 32'h1, 0, 0);
    idle();
    expect_v(SEL_CLR, 0, "R11 no hook on clear flag");
    // R5 disabled done does not set
    step(1, 1, 5'h04, 32'h0, 0, 0);
    step(0, 0, '0, '0, 1, 0);
    rd(5'h0C, 0, "R5 disabled done");
    expect_v(SEL_IRQ, 0, "R9 irq disabled");
    // R7 set wins over clear
    step(1, 1, 5'h04, 32'h1, 0, 0);
    step(1, 1, 5'h0C, 32'h1, 1, 0);
    rd(5'h0C, 1, "R7 set wins");
    expect_v(SEL_CLR, 0, "R11 no hook on collision");
    // R8 start and done together
    step(0, 0, '0, '0, 1, 1);
    rd(5'h10, 0, "R8 start beats done");
    // R2 / R3 soft reset with en=1, pend=1, status=0
    step(1, 1, 5'h00, 32'h1, 0, 0);
    idle();
    expect_v(SEL_RST, 1, "R2 pulse high");
    rd(5'h04, 0, "R3 enable restored");
    expect_v(SEL_RST, 0, "R2 pulse one cycle");
    rd(5'h0C, 0, "R3 pending restored");
    rd(5'h10, 1, "R3 status restored");
    expect_v(SEL_IRQ, 0, "R3 irq low");
    // R2 write of 0 gives no pulse
    step(1, 1, 5'h00, 32'h0, 0, 0);
    idle();
    expect_v(SEL_RST, 0, "R2 no pulse on zero");
    idle();
    #2;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule